// File: doc/BRIEF.md
# UART FIFO Level and Watermark Logic

This block sits between a UART's register port and its serializer and deserializer. It holds two data queues of equal, parameterised depth. The transmit queue is filled by the host and drained one word at a time by the serializer. A word leaves the queue as soon as the serializer takes it into its shift register. The receive queue is filled by the deserializer and drained by the host.

A small register port reports how full each queue is and how deep the queues are. It also holds a programmable receive threshold and a status word with error bits. When the receive queue holds at least the threshold number of words, a sticky ready flag is raised. Control inputs steer that flag to either an interrupt line or a DMA request line.

Software computes the free transmit space as the size value minus the transmit count. The threshold should be programmed below the queue depth.

Top module: `uart_fl_top`

## Requirements
- R1: After reset the transmit count (address 0) and receive count (address 3) read 0, the threshold (address 1) reads 1, and the status word (address 4) reads 0.
- R2: The transmit count at address 0 equals the number of words waiting in the transmit queue. A word taken by the serializer with `tx_take` is no longer counted.
- R3: Address 2 reads the queue depth parameter as a read-only value.
- R4: A write to address 1 while `rx_en` is low loads the threshold, and the new value reads back at once.
- R5: A write to address 1 while `rx_en` is high is ignored, and the previous threshold is kept.
- R6: The ready flag (status bit 4) is set no later than the clock edge at which the receive count becomes greater than or equal to the threshold.
- R7: The ready flag is sticky. Rewriting the threshold does not clear it. It clears only at a pop from the receive queue that leaves the count below the threshold.
- R8: `rx_irq` equals flag AND `rx_irq_en` AND NOT `dma_sel`. `rx_dma_req` equals flag AND `dma_sel`.
- R9: A push into a full queue is dropped, and the queue's overflow bit is set. This is status bit 0 for transmit and bit 2 for receive.
- R10: A pop from an empty queue returns the last word popped, and the queue's underflow bit is set. This is status bit 1 for transmit and bit 3 for receive.
- R11: Status bits 3:0 are cleared by writing 1 to them at address 4. Writing 0 leaves them unchanged.
- R12: Each queue returns words in arrival order. A push and a pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rx_en | input | 1 | Receiver enabled; locks the threshold |
| rx_irq_en | input | 1 | Receive interrupt enable |
| dma_sel | input | 1 | Route ready flag to DMA instead of interrupt |
| tx_wr | input | 1 | Host pushes a transmit word |
| tx_wdata | input | DW | Transmit word from host |
| tx_take | input | 1 | Serializer takes the head word |
| tx_data | output | DW | Head transmit word (last word when empty) |
| rx_put | input | 1 | Deserializer pushes a received word |
| rx_pdata | input | DW | Received word |
| rx_get | input | 1 | Host pops the head receive word |
| rx_data | output | DW | Head receive word (last word when empty) |
| rx_irq | output | 1 | Receive threshold interrupt |
| rx_dma_req | output | 1 | Receive threshold DMA request |

## Verification
Two functions can fall in the same cycle: a deserializer push and a host pop on the receive queue. The bench provokes this while the count sits exactly at the threshold. It then judges that the count holds, the flag stays set, and the popped word is the oldest one.

A second collision is a threshold write in the same cycle that the count meets it. The bench provokes this by lowering the threshold to the current count and expects the flag on the following sample.

// File: rtl/uart_fl_pkg.sv
package uart_fl_pkg;

  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    A_TXCNT  = 3'd0,
    A_RXMARK = 3'd1,
    A_SIZE   = 3'd2,
    A_RXCNT  = 3'd3,
    A_STAT   = 3'd4
  } reg_addr_e;

  // status bit positions
  localparam int S_TXOVF = 0;
  localparam int S_TXUNF = 1;
  localparam int S_RXOVF = 2;
  localparam int S_RXUNF = 3;
  localparam int S_READY = 4;

  function automatic logic mark_hit(input logic [REG_DW-1:0] level,
                                    input logic [REG_DW-1:0] mark);
    return level >= mark;
  endfunction

  function automatic logic ready_nx(input logic hit, input logic ready,
                                    input logic popped);
    return hit | (ready & ~popped);
  endfunction

endpackage

// File: rtl/uart_fl_fifo.sv
module uart_fl_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] level,
  output logic [CW-1:0] level_nx,
  output logic          pop_ok,
  output logic          ovf_ev,
  output logic          unf_ev
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [DW-1:0] last_q;
  logic          full, empty, push_ok;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);
  assign ovf_ev  = push & ~push_ok;
  assign unf_ev  = pop & empty;
  assign pop_data = empty ? last_q : mem[rd_q];

  always_comb begin
    unique case ({push_ok, pop_ok})
      2'b10:   level_nx = level + 1'b1;
      2'b01:   level_nx = level - 1'b1;
      default: level_nx = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      level  <= '0;
      last_q <= '0;
    end else begin
      level <= level_nx;
      if (push_ok) wr_q <= wrap_inc(wr_q);
      if (pop_ok) begin
        rd_q   <= wrap_inc(rd_q);
        last_q <= mem[rd_q];
      end
    end
  end

  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  p_drop_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (level == CW'(DEPTH)));
  p_empty_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> $stable(pop_data));
  p_pushpop_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(level));

endmodule

// File: rtl/uart_fl_rxmark.sv
module uart_fl_rxmark
  import uart_fl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_wr,
  input  logic [REG_DW-1:0] mark_wdata,
  input  logic              rx_en,
  input  logic [REG_DW-1:0] level,
  input  logic [REG_DW-1:0] level_nx,
  input  logic              popped,
  output logic [REG_DW-1:0] mark,
  output logic              ready
);

  logic [REG_DW-1:0] mark_nx;
  logic              wr_take, wr_ignored, hit_nx;

  assign wr_take    = mark_wr & ~rx_en;
  assign wr_ignored = mark_wr & rx_en;
  assign mark_nx    = wr_take ? mark_wdata : mark;
  assign hit_nx     = mark_hit(level_nx, mark_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark  <= REG_DW'(1);
      ready <= 1'b0;
    end else begin
      mark  <= mark_nx;
      ready <= ready_nx(hit_nx, ready, popped);
    end
  end

  p_mark_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> $stable(mark));
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= mark) |-> ready);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !popped) |=> ready);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ($past(popped) && level < mark));

endmodule

// File: rtl/uart_fl_top.sv
module uart_fl_top
  import uart_fl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          rx_en,
  input  logic          rx_irq_en,
  input  logic          dma_sel,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_take,
  output logic [DW-1:0] tx_data,
  input  logic          rx_put,
  input  logic [DW-1:0] rx_pdata,
  input  logic          rx_get,
  output logic [DW-1:0] rx_data,
  output logic          rx_irq,
  output logic          rx_dma_req
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     tx_lvl, tx_lvl_nx, rx_lvl, rx_lvl_nx;
  logic              tx_pop_ok, rx_pop_ok;
  logic              tx_ovf_ev, tx_unf_ev, rx_ovf_ev, rx_unf_ev;
  logic [REG_DW-1:0] mark;
  logic              ready;
  logic [3:0]        err_q, err_set, err_clr;
  logic              stat_wr;

  uart_fl_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr), .push_data(tx_wdata),
    .pop(tx_take), .pop_data(tx_data),
    .level(tx_lvl), .level_nx(tx_lvl_nx), .pop_ok(tx_pop_ok),
    .ovf_ev(tx_ovf_ev), .unf_ev(tx_unf_ev)
  );

  uart_fl_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_put), .push_data(rx_pdata),
    .pop(rx_get), .pop_data(rx_data),
    .level(rx_lvl), .level_nx(rx_lvl_nx), .pop_ok(rx_pop_ok),
    .ovf_ev(rx_ovf_ev), .unf_ev(rx_unf_ev)
  );

  uart_fl_rxmark u_mark (
    .clk(clk), .rst_n(rst_n),
    .mark_wr(reg_wr && reg_addr == A_RXMARK),
    .mark_wdata(reg_wdata),
    .rx_en(rx_en),
    .level(REG_DW'(rx_lvl)),
    .level_nx(REG_DW'(rx_lvl_nx)),
    .popped(rx_pop_ok),
    .mark(mark),
    .ready(ready)
  );

  assign stat_wr = reg_wr && reg_addr == A_STAT;
  assign err_set = {rx_unf_ev, rx_ovf_ev, tx_unf_ev, tx_ovf_ev};
  assign err_clr = stat_wr ? reg_wdata[3:0] : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_set | (err_q & ~err_clr);
  end

  assign rx_irq     = ready & rx_irq_en & ~dma_sel;
  assign rx_dma_req = ready & dma_sel;

  always_comb begin
    unique case (reg_addr)
      A_TXCNT:  reg_rdata = REG_DW'(tx_lvl);
      A_RXMARK: reg_rdata = mark;
      A_SIZE:   reg_rdata = REG_DW'(DEPTH);
      A_RXCNT:  reg_rdata = REG_DW'(rx_lvl);
      A_STAT:   reg_rdata = {3'b0, ready, err_q};
      default:  reg_rdata = '0;
    endcase
  end

  p_route_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_irq && rx_dma_req));
  p_tx_take_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop_ok && !tx_wr) |=> (tx_lvl == $past(tx_lvl) - 1'b1));
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[0] && !(stat_wr && reg_wdata[0])) |=> err_q[0]);

endmodule

// File: tb/uart_fl_top_bench.sv
module uart_fl_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int DW         = 8;

  logic          clk = 0, rst_n = 0;
  logic          reg_wr = 0;
  logic [2:0]    reg_addr = 0;
  logic [7:0]    reg_wdata = 0, reg_rdata;
  logic          rx_en = 0, rx_irq_en = 0, dma_sel = 0;
  logic          tx_wr = 0, tx_take = 0, rx_put = 0, rx_get = 0;
  logic [DW-1:0] tx_wdata = 0, rx_pdata = 0, tx_data, rx_data;
  logic          rx_irq, rx_dma_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fl_top #(.DEPTH(DEPTH), .DW(DW)) u_uart_fl_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_en(rx_en),
    .rx_irq_en(rx_irq_en), .dma_sel(dma_sel), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_take(tx_take), .tx_data(tx_data),
    .rx_put(rx_put), .rx_pdata(rx_pdata), .rx_get(rx_get),
    .rx_data(rx_data), .rx_irq(rx_irq), .rx_dma_req(rx_dma_req)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); check("R1 txcount", v, 0);
    rd(3, v); check("R1 rxcount", v, 0);
    rd(1, v); check("R1 mark",    v, 1);
    rd(4, v); check("R1 status",  v, 0);
    check("R1 irq/dma", {rx_irq, rx_dma_req}, 0);
  endtask

  task automatic t_depth();
    int v;
    rd(2, v); check("R3 size", v, DEPTH);
  endtask

  task automatic t_txcount();
    int v;
    for (int i = 0; i < 3; i++) begin
      tx_wr = 1; tx_wdata = 8'hA0 + 8'(i); tick();
    end
    tx_wr = 0;
    rd(0, v); check("R2 count after 3 pushes", v, 3);
    check("R12 tx head", tx_data, 8'hA0);
    tx_take = 1; tick(); tx_take = 0;
    rd(0, v); check("R2 word in shifter not counted", v, 2);
    check("R12 tx next", tx_data, 8'hA1);
    tx_take = 1; tick(); tick(); tx_take = 0;
    rd(0, v); check("R2 drained", v, 0);
  endtask

  task automatic t_mark();
    int v;
    rx_en = 0; wr(1, 8'd3);
    rd(1, v); check("R4 mark loaded", v, 3);
    rx_en = 1; wr(1, 8'd5);
    rd(1, v); check("R5 locked write ignored", v, 3);
  endtask

  task automatic t_flag();
    int v;
    rx_irq_en = 1; dma_sel = 0;
    for (int i = 0; i < 2; i++) begin
      rx_put = 1; rx_pdata = 8'hB0 + 8'(i); tick();
    end
    rx_put = 0;
    rd(4, v); check("R6 below mark no flag", (v >> 4) & 1, 0);
    check("R8 no irq", rx_irq, 0);
    rx_put = 1; rx_pdata = 8'hB2; tick(); rx_put = 0;
    rd(4, v); check("R6 flag at mark", (v >> 4) & 1, 1);
    check("R8 irq routed", {rx_irq, rx_dma_req}, 2'b10);
    dma_sel = 1; #1;
    check("R8 dma routed", {rx_irq, rx_dma_req}, 2'b01);
    dma_sel = 0; rx_irq_en = 0; #1;
    check("R8 irq disabled", {rx_irq, rx_dma_req}, 2'b00);
    rx_irq_en = 1;
    rx_en = 0; wr(1, 8'd6);
    rd(4, v); check("R7 rewrite keeps flag", (v >> 4) & 1, 1);
    check("R12 rx head", rx_data, 8'hB0);
    rx_get = 1; tick(); rx_get = 0;
    rd(4, v); check("R7 pop below mark clears", (v >> 4) & 1, 0);
    check("R8 irq cleared", rx_irq, 0);
    wr(1, 8'd2);
    rd(4, v); check("R6 lowered mark sets flag", (v >> 4) & 1, 1);
    // push and pop in the same cycle at the mark
    rx_put = 1; rx_pdata = 8'hB3; rx_get = 1; #1;
    check("R12 oldest popped", rx_data, 8'hB1);
    tick(); rx_put = 0; rx_get = 0;
    rd(3, v); check("R12 count held", v, 2);
    rd(4, v); check("R7 flag held on push+pop", (v >> 4) & 1, 1);
    check("R12 order B2", rx_data, 8'hB2);
    rx_get = 1; tick();
    check("R12 order B3", rx_data, 8'hB3);
    tick();
    check("R10 empty pop data", rx_data, 8'hB3);
    tick(); rx_get = 0;
    check("R10 empty pop keeps data", rx_data, 8'hB3);
    rd(4, v); check("R10 rx underflow bit", (v >> 3) & 1, 1);
    wr(4, 8'h00);
    rd(4, v); check("R11 zero write keeps bit", (v >> 3) & 1, 1);
    wr(4, 8'h08);
    rd(4, v); check("R11 w1c clears", v & 8'h0F, 0);
  endtask

  task automatic t_overflow();
    int v;
    for (int i = 0; i <= DEPTH; i++) begin
      tx_wr = 1; tx_wdata = 8'h40 + 8'(i); tick();
    end
    tx_wr = 0;
    rd(0, v); check("R9 count capped", v, DEPTH);
    rd(4, v); check("R9 tx overflow bit", v & 1, 1);
    for (int i = 0; i < DEPTH; i++) begin
      tx_take = 1; #1;
      check("R9 content intact", tx_data, 8'h40 + i);
      tick();
    end
    rd(0, v); check("R2 empty after drain", v, 0);
    tick(); tx_take = 0;
    check("R10 tx last data", tx_data, 8'h40 + DEPTH - 1);
    rd(4, v); check("R10 tx underflow bit", (v >> 1) & 1, 1);
    wr(4, 8'h03);
    rd(4, v); check("R11 tx bits cleared", v & 3, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_n = 1; tick();
    t_reset();
    t_depth();
    t_txcount();
    t_mark();
    t_flag();
    t_overflow();
    finish_run();
  end

endmodule